// File: doc/BRIEF.md
# Stuck-Bus Recovery Sequencer for a Two-Wire Byte Controller

This block sits between the transaction logic and a two-wire (I2C) byte controller. It runs once before each transfer. When the transaction logic asks for the bus, the sequencer watches the controller's bus-busy flag. If the flag drops, it reports that the bus is free. If the flag stays set past a long busy limit, it reports a timeout. At that same point it samples the controller's full status byte.

A slave can hang partway through an acknowledge and keep holding the bus. The controller then shows a status byte with the complete, busy and no-acknowledge bits set and every other bit clear. Only in that case does the sequencer write five fixed control words to the controller, one at a time, with a gap between writes. This forces an extra clock pulse and a START/STOP onto the bus, which frees the slave. A done pulse follows the last gap.

An abort request during the busy wait turns the controller off and reports an interrupted status. All delays come from a prescaled tick that is derived from the system clock frequency.

Top module: `busrec_seq`

## Requirements
- R1: While reset is asserted and after it is released, `active_o`, `ctrl_we_o` and all four result pulses are low.
- R2: A `start_i` seen while idle begins the busy wait, and `active_o` is high from the next cycle. If `bus_busy_i` is seen low during the wait, `ready_o` pulses for one cycle, registered at the edge that samples it, and the block returns to idle with no control write.
- R3: If `bus_busy_i` stays high, `timeout_o` pulses `BUSY_TICKS*DIV+1` cycles after the edge that accepted `start_i`, where `DIV = CLK_HZ/TICK_HZ`.
- R4: Recovery starts only if the status byte at the timeout edge equals exactly 0xA1 (bit 7 transfer complete, bit 5 bus busy, bit 0 no acknowledge). Any other value returns the block to idle after the timeout, with no control write.
- R5: Recovery writes these control words in order: 0x00, 0x80, 0x30, 0xB0, 0x80. In the control byte, bit 7 is controller enable, bit 5 is master/START and bit 4 is transmit.
- R6: The first recovery write comes one cycle after the timeout pulse. Each later write comes `GAP_TICKS*DIV+2` cycles after the one before it.
- R7: `done_o` pulses `GAP_TICKS*DIV+1` cycles after the fifth write, and the block is idle in that same cycle.
- R8: An `abort_i` seen during the busy wait produces one control write of 0x00 together with an `intr_o` pulse, and the block returns to idle. Abort takes priority over a bus-free indication and over the busy timeout when they fall in the same cycle.
- R9: When a bus-free indication and the busy timeout fall in the same cycle, `ready_o` wins and `timeout_o` stays low.
- R10: `start_i` and `abort_i` are ignored during recovery. The five writes and the done pulse are unchanged, and the block stays idle afterwards.
- R11: At most one of `ready_o`, `timeout_o`, `intr_o` and `done_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request from the transaction logic to begin the pre-transfer busy wait |
| abort_i | input | 1 | External abort request, acted on during the busy wait |
| bus_busy_i | input | 1 | Bus-busy flag from the byte controller |
| status_i | input | 8 | Full status byte from the byte controller |
| active_o | output | 1 | High while waiting or recovering |
| ctrl_we_o | output | 1 | One-cycle strobe that writes `ctrl_o` into the controller's control register |
| ctrl_o | output | 8 | Control word to be written |
| ready_o | output | 1 | Pulse: bus seen free, the transfer may go ahead |
| timeout_o | output | 1 | Pulse: busy limit reached (I/O error) |
| intr_o | output | 1 | Pulse: wait interrupted by abort |
| done_o | output | 1 | Pulse: recovery script finished |

## Verification
Three exits from the busy wait can meet in a single cycle: abort, bus-free and busy timeout. The bench provokes each collision by driving abort, the bus-busy release, or both, so that they are sampled on exactly the edge where the busy timer has run out. It then judges the result by which one pulse appears and whether a control write of 0x00 comes with it. A fourth case drives trigger and abort together in the middle of a recovery gap. It checks that the script's word values, their cycle stamps and the done pulse are unchanged.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STEP,
    ST_GAP
  } seq_state_e;

  // control-register bits decoded by the byte controller
  localparam logic [7:0] CR_ENABLE = 8'h80;
  localparam logic [7:0] CR_MASTER = 8'h20;
  localparam logic [7:0] CR_XMIT   = 8'h10;

  // status-register bits
  localparam logic [7:0] SR_COMPLETE = 8'h80;
  localparam logic [7:0] SR_BUSY     = 8'h20;
  localparam logic [7:0] SR_NACK     = 8'h01;
  localparam logic [7:0] SR_STUCK    = SR_COMPLETE | SR_BUSY | SR_NACK;

  localparam int unsigned SCRIPT_LEN = 5;

  // control word played at each script step
  function automatic logic [7:0] script_word(input logic [2:0] idx);
    case (idx)
      3'd0:    script_word = 8'h00;
      3'd1:    script_word = CR_ENABLE;
      3'd2:    script_word = CR_MASTER | CR_XMIT;
      3'd3:    script_word = CR_MASTER | CR_XMIT | CR_ENABLE;
      default: script_word = CR_ENABLE;
    endcase
  endfunction

  function automatic logic is_stuck(input logic [7:0] status);
    return status == SR_STUCK;
  endfunction

endpackage

// File: rtl/busrec_tick_div.sv
module busrec_tick_div #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick_o = (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || tick_o) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/busrec_timer.sv
module busrec_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          expired_o
);
  logic [TW-1:0] cnt;

  assign expired_o = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (tick && !expired_o)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned TICK_HZ    = 1_000_000,
  parameter int unsigned GAP_TICKS  = 30,
  parameter int unsigned BUSY_TICKS = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       bus_busy_i,
  input  logic [7:0] status_i,
  output logic       active_o,
  output logic       ctrl_we_o,
  output logic [7:0] ctrl_o,
  output logic       ready_o,
  output logic       timeout_o,
  output logic       intr_o,
  output logic       done_o
);
  localparam int unsigned DIV      = CLK_HZ / TICK_HZ;
  localparam int unsigned MAX_T    = (BUSY_TICKS > GAP_TICKS) ? BUSY_TICKS : GAP_TICKS;
  localparam int unsigned TW       = $clog2(MAX_T + 1);
  localparam logic [2:0]  LAST_IDX = 3'(SCRIPT_LEN - 1);

  seq_state_e    state;
  logic [2:0]    idx;
  logic          tick;
  logic          tmr_expired;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;

  // named internal events
  logic accept_w, abort_hit_w, bus_free_w, wait_expired_w, gap_done_w;

  assign accept_w       = (state == ST_IDLE) && start_i;
  assign abort_hit_w    = (state == ST_WAIT) && abort_i;
  assign bus_free_w     = (state == ST_WAIT) && !abort_i && !bus_busy_i;
  assign wait_expired_w = (state == ST_WAIT) && !abort_i && bus_busy_i && tmr_expired;
  assign gap_done_w     = (state == ST_GAP) && tmr_expired;

  assign tmr_load = accept_w || (state == ST_STEP);
  assign tmr_val  = (state == ST_IDLE) ? TW'(BUSY_TICKS) : TW'(GAP_TICKS);
  assign active_o = (state != ST_IDLE);

  busrec_tick_div #(.DIV(DIV)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_load),
    .tick_o  (tick)
  );

  busrec_timer #(.TW(TW)) tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tmr_load),
    .load_val  (tmr_val),
    .tick      (tick),
    .expired_o (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      ctrl_we_o <= 1'b0;
      ctrl_o    <= '0;
      ready_o   <= 1'b0;
      timeout_o <= 1'b0;
      intr_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      ctrl_we_o <= 1'b0;
      ready_o   <= 1'b0;
      timeout_o <= 1'b0;
      intr_o    <= 1'b0;
      done_o    <= 1'b0;
      case (state)
        ST_IDLE: if (accept_w) state <= ST_WAIT;
        ST_WAIT: begin
          if (abort_hit_w) begin
            ctrl_we_o <= 1'b1;
            ctrl_o    <= 8'h00;
            intr_o    <= 1'b1;
            state     <= ST_IDLE;
          end else if (bus_free_w) begin
            ready_o <= 1'b1;
            state   <= ST_IDLE;
          end else if (wait_expired_w) begin
            timeout_o <= 1'b1;
            if (is_stuck(status_i)) begin
              idx   <= '0;
              state <= ST_STEP;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_STEP: begin
          ctrl_we_o <= 1'b1;
          ctrl_o    <= script_word(idx);
          state     <= ST_GAP;
        end
        default: begin
          if (gap_done_w) begin
            if (idx == LAST_IDX) begin
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_STEP;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/busrec_seq_chk.sv
module busrec_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [7:0] status_i,
  input logic       active_o,
  input logic       ctrl_we_o,
  input logic [7:0] ctrl_o,
  input logic       ready_o,
  input logic       timeout_o,
  input logic       intr_o,
  input logic       done_o,
  input logic       gap_done_w
);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready_o, timeout_o, intr_o, done_o}));

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> (ctrl_we_o && ctrl_o == 8'h00 && !active_o));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!active_o && $past(gap_done_w)));

  // R4
  no_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && $past(status_i) != 8'hA1) |-> !active_o);

  // R4
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && $past(status_i) == 8'hA1) |-> active_o);

  // R2
  trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && start_i) |=> active_o);

  // R5
  script_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we_o |-> (ctrl_o inside {8'h00, 8'h80, 8'h30, 8'hB0}));
endmodule

bind busrec_seq busrec_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .status_i   (status_i),
  .active_o   (active_o),
  .ctrl_we_o  (ctrl_we_o),
  .ctrl_o     (ctrl_o),
  .ready_o    (ready_o),
  .timeout_o  (timeout_o),
  .intr_o     (intr_o),
  .done_o     (done_o),
  .gap_done_w (gap_done_w)
);

// File: tb/busrec_seq_tb.sv
module busrec_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIVB = 4;
  localparam int NB   = 20;
  localparam int GB   = 3;
  localparam int TO_LAT  = NB * DIVB + 1;  // trigger edge -> timeout
  localparam int STEP_SP = GB * DIVB + 2;  // write -> next write
  localparam int DONE_LAT = GB * DIVB + 1; // fifth write -> done

  // vector: {status[7:0], mode[2:0], delay[7:0]}
  // mode 0 release bus, 1 abort, 2 hold busy, 3 abort+release, 4 hold + poke during recovery
  localparam int NV = 10;
  localparam logic [18:0] VECS [0:NV-1] = '{
    {8'hA1, 3'd2, 8'd0},
    {8'hA0, 3'd2, 8'd0},
    {8'hA3, 3'd2, 8'd0},
    {8'h21, 3'd2, 8'd0},
    {8'h00, 3'd0, 8'd5},
    {8'hA1, 3'd0, 8'd1},
    {8'hA1, 3'd1, 8'd7},
    {8'hA1, 3'd1, 8'd81},
    {8'hA1, 3'd0, 8'd81},
    {8'hA1, 3'd3, 8'd81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic abort_i = 1'b0;
  logic bus_busy_i = 1'b1;
  logic [7:0] status_i = 8'h00;
  logic active_o, ctrl_we_o, ready_o, timeout_o, intr_o, done_o;
  logic [7:0] ctrl_o;

  busrec_seq #(
    .CLK_HZ(DIVB), .TICK_HZ(1), .GAP_TICKS(GB), .BUSY_TICKS(NB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .bus_busy_i(bus_busy_i), .status_i(status_i), .active_o(active_o),
    .ctrl_we_o(ctrl_we_o), .ctrl_o(ctrl_o), .ready_o(ready_o),
    .timeout_o(timeout_o), .intr_o(intr_o), .done_o(done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int wr_n, rdy_n, to_n, intr_n, done_n, ovl;
  int rdy_cyc, to_cyc, intr_cyc, done_cyc;
  int wr_val [8];
  int wr_cyc [8];

  always @(negedge clk) begin
    if (rst_n) begin
      if (ctrl_we_o) begin
        if (wr_n < 8) begin
          wr_val[wr_n] = int'(ctrl_o);
          wr_cyc[wr_n] = cyc;
        end
        wr_n++;
      end
      if (ready_o)   begin rdy_n++;  rdy_cyc  = cyc; end
      if (timeout_o) begin to_n++;   to_cyc   = cyc; end
      if (intr_o)    begin intr_n++; intr_cyc = cyc; end
      if (done_o)    begin done_n++; done_cyc = cyc; end
      if (int'(ready_o) + int'(timeout_o) + int'(intr_o) + int'(done_o) > 1) ovl++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_n = 0; rdy_n = 0; to_n = 0; intr_n = 0; done_n = 0;
    rdy_cyc = -1; to_cyc = -1; intr_cyc = -1; done_cyc = -1;
  endtask

  function automatic int exp_word(input int i);
    logic [7:0] en, ms, tx;
    en = 8'h80; ms = 8'h20; tx = 8'h10;
    case (i)
      0: return 0;
      1: return int'(en);
      2: return int'(ms | tx);
      3: return int'(ms | tx | en);
      default: return int'(en);
    endcase
  endfunction

  task automatic run_vec(input logic [7:0] stat, input int mode, input int dly);
    int s;
    clear_log();
    @(negedge clk);
    status_i = stat; bus_busy_i = 1'b1; start_i = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
    if (mode == 4) begin
      repeat (dly - 1) @(negedge clk);
      start_i = 1'b1; abort_i = 1'b1;
      repeat (2) @(negedge clk);
      start_i = 1'b0; abort_i = 1'b0;
    end else if (mode != 2) begin
      repeat (dly - 1) @(negedge clk);
      if (mode == 1 || mode == 3) abort_i = 1'b1;
      if (mode == 0 || mode == 3) bus_busy_i = 1'b0;
      @(negedge clk);
      abort_i = 1'b0;
    end
    for (int k = 0; k < 2000 && active_o; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
    chk("R10", "active after settle", int'(active_o), 0);
    bus_busy_i = 1'b1;
    if (mode == 0 && dly < TO_LAT + 1) begin
      chk("R2", "ready count", rdy_n, 1);
      chk("R2", "ready cycle", rdy_cyc - s, dly);
      chk("R2", "writes on free bus", wr_n, 0);
      chk("R9", "timeout when free wins", to_n, 0);
    end else if (mode == 1 || mode == 3) begin
      chk("R8", "intr count", intr_n, 1);
      chk("R8", "intr cycle", intr_cyc - s, dly);
      chk("R8", "abort writes", wr_n, 1);
      chk("R8", "abort word", wr_val[0], 0);
      chk("R8", "ready on abort", rdy_n, 0);
      chk("R8", "timeout on abort", to_n, 0);
    end else begin
      chk("R3", "timeout count", to_n, 1);
      chk("R3", "timeout cycle", to_cyc - s, TO_LAT);
      if (stat == 8'hA1) begin
        chk("R5", "write count", wr_n, 5);
        for (int i = 0; i < 5; i++) begin
          chk("R5", "script word", wr_val[i], exp_word(i));
          chk("R6", "write cycle", wr_cyc[i] - to_cyc, 1 + i * STEP_SP);
        end
        chk("R7", "done count", done_n, 1);
        chk("R7", "done cycle", done_cyc - wr_cyc[4], DONE_LAT);
        if (mode == 4) chk("R10", "intr during recovery", intr_n, 0);
      end else begin
        chk("R4", "writes without stuck pattern", wr_n, 0);
        chk("R4", "done without stuck pattern", done_n, 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ovl = 0;
    clear_log();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "active in reset", int'(active_o), 0);
    chk("R1", "we in reset", int'(ctrl_we_o), 0);
    chk("R1", "pulses in reset", int'(ready_o | timeout_o | intr_o | done_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "active after reset", int'(active_o), 0);
    chk("R1", "we after reset", int'(ctrl_we_o), 0);

    for (int v = 0; v < NV; v++)
      run_vec(VECS[v][18:11], int'(VECS[v][10:8]), int'(VECS[v][7:0]));

    // R10: trigger and abort poked inside the recovery gaps
    run_vec(8'hA1, 4, 100);
    // R2: back-to-back normal wait after recovery
    run_vec(8'h00, 0, 3);

    chk("R11", "overlapping pulses", ovl, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule